// File: doc/BRIEF.md
# Two-Wire Slave Register Interface

This block is a slave on an open-drain two-wire serial bus. It runs from a fast system clock, oversamples the clock line and the data line, and cleans both through a synchroniser and a glitch filter before it looks for edges. It recognises the START and STOP bus conditions and matches a 7-bit device address. The top six bits of that address are fixed and the last bit comes from a pin. It acknowledges bytes by pulling the data line low.

A write transfer works as follows. The byte after the address byte loads an internal register pointer. Any further bytes in the same transfer are stored in the register that the pointer selects. A read transfer returns the selected register MSB first. The pointer keeps its value between transfers and never advances on its own, so a host normally sets the pointer and then uses a repeated START to read.

The one exception to this is the 16-bit temperature value. A read that starts at its high byte continues with its low byte. Both bytes come from a copy of the temperature taken when the read address is acknowledged, so the pair always belongs together. The divider select, control and tuning bytes are driven straight out to the rest of the chip.

Top module: `twowire_regslave`

## Requirements
- R1: The slave acknowledges only the address byte whose upper seven bits equal 100010 followed by the address pin. Address bit 0 is the direction: 0 means the master writes and 1 means the master reads. On a match, the slave holds SDA low through the ninth clock. On a mismatch, it leaves SDA released and ignores everything until the next START.
- R2: A falling SDA while SCL is high starts a transfer, and a repeated START begins a new one. A rising SDA while SCL is high ends the transfer. Bytes clocked without a preceding START have no effect.
- R3: In a write transfer, the first byte after the address sets the pointer. Every later byte writes the register at that pointer, so extra bytes overwrite the same register. The registers are divider select at 5Dh, control at 60h and tuning offset at 66h. Each one appears on its output port once its data byte is taken.
- R4: A read returns the register at the pointer, MSB first. SDA changes only while SCL is low.
- R5: The pointer survives a STOP and never increments. A read with no new pointer returns the last selected register. An acknowledged continuation of a read returns that same register again.
- R6: The temperature high byte is at 64h and the low byte at 65h. A read at 64h that the master acknowledges continues with the low byte. Both bytes come from a copy of the temperature input taken when the read address is acknowledged.
- R7: A write to 64h or 65h is acknowledged but changes nothing. Addresses outside the map read as 00h and ignore writes.
- R8: When the master answers a read byte with NACK, the slave keeps SDA released until the next START or STOP.
- R9: After reset, the divider select, control and tuning registers are 00h and SDA is released.
- R10: A pulse on SCL or SDA shorter than the filter length does not count as an edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| addr_pin_i | input | 1 | Selects the lowest device address bit |
| temp_i | input | 16 | Current temperature word from the sensor |
| div_sel_o | output | 8 | Divider select register |
| ctrl_o | output | 8 | Control register |
| tune_o | output | 8 | Tuning offset register |

## Verification
The hardest state to reach is the middle of a two-byte temperature read. The slave must already have taken its copy of the temperature and be waiting for the master's acknowledge to decide between sending the low byte and releasing the line. The stimulus gets there by setting the pointer to 64h and issuing a repeated START with the read address. It then changes the temperature input between the two bytes, so that a design reading the live value rather than its copy returns the wrong low byte. A separate transfer reaches the state after a master NACK on a register whose next bit would be 0, which shows whether the slave wrongly keeps driving.

// File: rtl/tw_pkg.sv
// Shared constants and state encoding for the two-wire register slave.
// Assumes byte-wide registers and 7-bit addressing.
package tw_pkg;
    localparam int BYTE_BITS = 8;
    localparam int BCNT_W    = $clog2(BYTE_BITS + 1);

    localparam logic [5:0] DEV_ADDR_HI = 6'b100010;

    localparam logic [7:0] REG_DIV     = 8'h5D;
    localparam logic [7:0] REG_CTRL    = 8'h60;
    localparam logic [7:0] REG_TEMP_HI = 8'h64;
    localparam logic [7:0] REG_TEMP_LO = 8'h65;
    localparam logic [7:0] REG_TUNE    = 8'h66;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_PTR,
        ST_WDATA,
        ST_READ,
        ST_WAIT
    } tw_state_t;
endpackage

// File: rtl/tw_line_filter.sv
// Synchronises one bus line into the clock domain and rejects pulses shorter
// than FILT_CYC cycles. Assumes the line idles high; the output resets high.
module tw_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_CYC    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CW = $clog2(FILT_CYC + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          run_cnt;
    logic                   synced;

    assign synced = sync_q[SYNC_STAGES-1];

    // Metastability chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
    end

    // Accept a new level only after it persists for FILT_CYC cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
            line_o  <= 1'b1;
        end else if (synced == line_o) begin
            run_cnt <= '0;
        end else if (run_cnt == CW'(FILT_CYC - 1)) begin
            line_o  <= synced;
            run_cnt <= '0;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/tw_regfile.sv
// Register bank behind the bus slave: three writable bytes and a read-only
// temperature snapshot. Writes to unmapped or read-only addresses are dropped.
module tw_regfile
    import tw_pkg::*;
#(
    parameter int          TEMP_W   = 16,
    parameter logic [7:0]  DIV_RST  = 8'h00,
    parameter logic [7:0]  CTRL_RST = 8'h00,
    parameter logic [7:0]  TUNE_RST = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [7:0]        rd_addr,
    input  logic [TEMP_W-1:0] temp_snap,
    output logic [7:0]        rd_data,
    output logic [7:0]        div_o,
    output logic [7:0]        ctrl_o,
    output logic [7:0]        tune_o
);
    // Store a byte into the one writable register it addresses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_o  <= DIV_RST;
            ctrl_o <= CTRL_RST;
            tune_o <= TUNE_RST;
        end else if (wr_en) begin
            case (wr_addr)
                REG_DIV:  div_o  <= wr_data;
                REG_CTRL: ctrl_o <= wr_data;
                REG_TUNE: tune_o <= wr_data;
                default:  ;
            endcase
        end
    end

    // Read multiplexer; unmapped addresses return zero.
    always_comb begin
        case (rd_addr)
            REG_DIV:     rd_data = div_o;
            REG_CTRL:    rd_data = ctrl_o;
            REG_TEMP_HI: rd_data = temp_snap[TEMP_W-1 -: 8];
            REG_TEMP_LO: rd_data = temp_snap[7:0];
            REG_TUNE:    rd_data = tune_o;
            default:     rd_data = 8'h00;
        endcase
    end
endmodule

// File: rtl/twowire_regslave.sv
// Two-wire bus slave with a pointer-addressed register bank.
// Assumes clk runs at least 4*(SYNC_STAGES+FILT_CYC+2) times faster than SCL
// and that the master never stretches or stops mid-bit. SDA is driven only
// low (sda_oe_o = 1); the pad and pull-up are outside.
module twowire_regslave
    import tw_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_CYC    = 4,
    parameter int TEMP_W      = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic              addr_pin_i,
    input  logic [TEMP_W-1:0] temp_i,
    output logic [7:0]        div_sel_o,
    output logic [7:0]        ctrl_o,
    output logic [7:0]        tune_o
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw_lines, filt_lines;
    logic scl_f, sda_f, scl_q, sda_q;
    logic start_ev, stop_ev, scl_rise, scl_fall;

    tw_state_t           state;
    logic [BCNT_W-1:0]   bitcnt;
    logic                ack_phase, rw_q;
    logic [7:0]          ptr_q, shreg, txsh, rd_data, cont_byte;
    logic [TEMP_W-1:0]   temp_snap;
    logic                addr_hit, byte_full, wr_en;

    assign raw_lines = {scl_i, sda_i};

    // One filter per bus line.
    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        tw_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_CYC   (FILT_CYC)
        ) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .line_i(raw_lines[g]),
            .line_o(filt_lines[g])
        );
    end

    assign scl_f = filt_lines[1];
    assign sda_f = filt_lines[0];

    // Previous filtered levels for edge and bus-condition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    assign start_ev  = scl_f & scl_q & sda_q & ~sda_f;
    assign stop_ev   = scl_f & scl_q & ~sda_q & sda_f;
    assign scl_rise  = scl_f & ~scl_q;
    assign scl_fall  = ~scl_f & scl_q;

    assign addr_hit  = (shreg[7:1] == {DEV_ADDR_HI, addr_pin_i});
    assign byte_full = (bitcnt == BCNT_W'(BYTE_BITS));
    assign cont_byte = (ptr_q == REG_TEMP_HI) ? temp_snap[7:0] : rd_data;
    assign wr_en     = scl_fall && !ack_phase && byte_full && (state == ST_WDATA);

    // Transfer sequencer: receive on SCL rise, drive SDA after SCL fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            bitcnt    <= '0;
            ack_phase <= 1'b0;
            rw_q      <= 1'b0;
            ptr_q     <= 8'h00;
            shreg     <= 8'h00;
            txsh      <= 8'h00;
            sda_oe_o  <= 1'b0;
            temp_snap <= '0;
        end else if (start_ev) begin
            state     <= ST_ADDR;
            bitcnt    <= '0;
            ack_phase <= 1'b0;
            sda_oe_o  <= 1'b0;
        end else if (stop_ev) begin
            state     <= ST_IDLE;
            bitcnt    <= '0;
            ack_phase <= 1'b0;
            sda_oe_o  <= 1'b0;
        end else if (scl_rise) begin
            case (state)
                ST_ADDR, ST_PTR, ST_WDATA: begin
                    if (!ack_phase) begin
                        shreg  <= {shreg[6:0], sda_f};
                        bitcnt <= bitcnt + 1'b1;
                    end
                end
                ST_READ: begin
                    if (ack_phase) begin
                        if (sda_f) begin
                            state     <= ST_WAIT;
                            ack_phase <= 1'b0;
                        end
                    end else begin
                        bitcnt <= bitcnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end else if (scl_fall) begin
            if (ack_phase) begin
                ack_phase <= 1'b0;
                bitcnt    <= '0;
                sda_oe_o  <= 1'b0;
                case (state)
                    ST_ADDR: begin
                        if (rw_q) begin
                            state    <= ST_READ;
                            txsh     <= rd_data;
                            sda_oe_o <= ~rd_data[7];
                        end else begin
                            state <= ST_PTR;
                        end
                    end
                    ST_PTR:  state <= ST_WDATA;
                    ST_READ: begin
                        txsh     <= cont_byte;
                        sda_oe_o <= ~cont_byte[7];
                    end
                    default: ;
                endcase
            end else if (byte_full) begin
                case (state)
                    ST_ADDR: begin
                        if (addr_hit) begin
                            ack_phase <= 1'b1;
                            sda_oe_o  <= 1'b1;
                            rw_q      <= shreg[0];
                            if (shreg[0]) temp_snap <= temp_i;
                        end else begin
                            state <= ST_WAIT;
                        end
                    end
                    ST_PTR: begin
                        ptr_q     <= shreg;
                        ack_phase <= 1'b1;
                        sda_oe_o  <= 1'b1;
                    end
                    ST_WDATA: begin
                        ack_phase <= 1'b1;
                        sda_oe_o  <= 1'b1;
                    end
                    ST_READ: begin
                        ack_phase <= 1'b1;
                        sda_oe_o  <= 1'b0;
                    end
                    default: ;
                endcase
            end else if (state == ST_READ && bitcnt != '0) begin
                txsh     <= {txsh[6:0], 1'b0};
                sda_oe_o <= ~txsh[6];
            end
        end
    end

    tw_regfile #(
        .TEMP_W(TEMP_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (ptr_q),
        .wr_data  (shreg),
        .rd_addr  (ptr_q),
        .temp_snap(temp_snap),
        .rd_data  (rd_data),
        .div_o    (div_sel_o),
        .ctrl_o   (ctrl_o),
        .tune_o   (tune_o)
    );
endmodule

// File: rtl/tw_regslave_chk.sv
// Protocol and register checks for twowire_regslave, attached by bind.
module tw_regslave_chk
    import tw_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      scl_f,
    input logic      start_ev,
    input logic      stop_ev,
    input tw_state_t state,
    input logic      sda_oe_o,
    input logic      wr_en,
    input logic [7:0] wr_addr,
    input logic [7:0] div_sel_o,
    input logic [7:0] ctrl_o,
    input logic [7:0] tune_o
);
    // R4: the slave alters SDA only while SCL is low (or on a bus condition).
    a_r4_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe_o) |-> (!scl_f || $past(start_ev) || $past(stop_ev)));

    // R9: an idle slave never holds the line.
    a_r9_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> !sda_oe_o);

    // R8 and R1: after a master NACK or an address miss, SDA stays released.
    a_r8_wait_released: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> !sda_oe_o);

    // R2: STOP returns to idle, START begins address reception.
    a_r2_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> (state == ST_IDLE));
    a_r2_start_addr: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (state == ST_ADDR));

    // R7: writes aimed at the temperature bytes leave every register alone.
    a_r7_temp_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == REG_TEMP_HI || wr_addr == REG_TEMP_LO))
        |=> ($stable(div_sel_o) && $stable(ctrl_o) && $stable(tune_o)));

    // R3: registers change only after a data byte, and one at a time.
    a_r3_change_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> ($stable(div_sel_o) && $stable(ctrl_o) && $stable(tune_o)));
    a_r3_one_reg_per_byte: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({!$stable(div_sel_o), !$stable(ctrl_o), !$stable(tune_o)}) <= 1);
endmodule

bind twowire_regslave tw_regslave_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_f    (scl_f),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .state    (state),
    .sda_oe_o (sda_oe_o),
    .wr_en    (wr_en),
    .wr_addr  (ptr_q),
    .div_sel_o(div_sel_o),
    .ctrl_o   (ctrl_o),
    .tune_o   (tune_o)
);

// File: tb/tb_twowire_regslave.sv
// Bench for twowire_regslave: bit-banged bus master, vector table, directed tests.
module tb_twowire_regslave;
    localparam int Q = 12;  // system clocks per quarter of an SCL bit

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic a0_pin = 1'b0;
    logic [15:0] temp = 16'h4B00;
    logic sda_oe;
    logic [7:0] div_o, ctrl_o, tune_o;
    wire  sda_bus = sda_m & ~sda_oe;

    int n_vec = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    twowire_regslave dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_bus),
        .sda_oe_o  (sda_oe),
        .addr_pin_i(a0_pin),
        .temp_i    (temp),
        .div_sel_o (div_o),
        .ctrl_o    (ctrl_o),
        .tune_o    (tune_o)
    );

    // {pointer, written byte, expected read-back}
    localparam logic [23:0] VEC [8] = '{
        {8'h5D, 8'h3C, 8'h3C},
        {8'h60, 8'h0B, 8'h0B},
        {8'h66, 8'hE8, 8'hE8},
        {8'h64, 8'hAA, 8'h4B},
        {8'h65, 8'h55, 8'h00},
        {8'h70, 8'h12, 8'h00},
        {8'h5D, 8'hFF, 8'hFF},
        {8'h66, 8'h80, 8'h80}
    };

    function automatic logic [7:0] abyte(input logic a, input logic rd);
        return {6'b100010, a, rd};
    endfunction

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic send_byte(input logic [7:0] b, input logic glitch, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i];
            if (glitch && i == 4) begin
                repeat (3) @(negedge clk);
                scl_m = 1'b1;
                repeat (2) @(negedge clk);
                scl_m = 1'b0;
            end
            wq();
            scl_m = 1'b1; wq();
            scl_m = 1'b0; wq();
        end
        sda_m = 1'b1; wq();
        scl_m = 1'b1;
        repeat (Q/2) @(negedge clk);
        acked = ~sda_bus;
        repeat (Q/2) @(negedge clk);
        scl_m = 1'b0; wq();
    endtask

    task automatic recv_byte(input logic nack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; wq();
            scl_m = 1'b1;
            repeat (Q/2) @(negedge clk);
            d[i] = sda_bus;
            repeat (Q/2) @(negedge clk);
            scl_m = 1'b0; wq();
        end
        sda_m = nack; wq();
        scl_m = 1'b1; wq();
        scl_m = 1'b0; wq();
        sda_m = 1'b1;
    endtask

    task automatic wr_reg(input logic ma, input logic [7:0] p, input logic [7:0] d,
                          input logic glitch, output logic ak);
        logic x;
        bus_start();
        send_byte(abyte(ma, 1'b0), 1'b0, ak);
        send_byte(p, 1'b0, x);
        send_byte(d, glitch, x);
        bus_stop();
    endtask

    task automatic rd_reg(input logic [7:0] p, output logic [7:0] d);
        logic x;
        bus_start();
        send_byte(abyte(1'b0, 1'b0), 1'b0, x);
        send_byte(p, 1'b0, x);
        bus_start();
        send_byte(abyte(1'b0, 1'b1), 1'b0, x);
        recv_byte(1'b1, d);
        bus_stop();
    endtask

    // Watchdog: a hung run is reported as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic       ak, x;
        logic [7:0] d, d2;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R9: reset state
        check("R9 div reset", div_o, 8'h00);
        check("R9 ctrl reset", ctrl_o, 8'h00);
        check("R9 tune reset", tune_o, 8'h00);
        check("R9 sda released", sda_oe, 1'b0);

        // Vector table: write then read back (R3, R4, R7)
        for (int i = 0; i < 8; i++) begin
            wr_reg(1'b0, VEC[i][23:16], VEC[i][15:8], 1'b0, ak);
            check("R1 address ack", ak, 1'b1);
            rd_reg(VEC[i][23:16], d);
            check("R3/R4/R7 readback", d, VEC[i][7:0]);
        end
        check("R3 div port", div_o, 8'hFF);
        check("R3 ctrl port", ctrl_o, 8'h0B);
        check("R3 tune port", tune_o, 8'h80);

        // R10: SCL glitch inside a data byte's low phase
        wr_reg(1'b0, 8'h5D, 8'hA5, 1'b1, ak);
        check("R10 glitch rejected", div_o, 8'hA5);

        // R1: address pin mismatch, then match
        a0_pin = 1'b1;
        wr_reg(1'b0, 8'h5D, 8'h11, 1'b0, ak);
        check("R1 mismatch not acked", ak, 1'b0);
        check("R1 mismatch no write", div_o, 8'hA5);
        wr_reg(1'b1, 8'h5D, 8'h5A, 1'b0, ak);
        check("R1 pin address acked", ak, 1'b1);
        check("R1 pin address write", div_o, 8'h5A);
        a0_pin = 1'b0;

        // R3: extra bytes overwrite the same register
        bus_start();
        send_byte(abyte(1'b0, 1'b0), 1'b0, x);
        send_byte(8'h66, 1'b0, x);
        send_byte(8'h11, 1'b0, x);
        send_byte(8'h22, 1'b0, x);
        bus_stop();
        check("R3 same register rewritten", tune_o, 8'h22);
        check("R3 neighbour untouched", ctrl_o, 8'h0B);

        // R6: two-byte temperature read from a snapshot
        temp = 16'hFF80;
        bus_start();
        send_byte(abyte(1'b0, 1'b0), 1'b0, x);
        send_byte(8'h64, 1'b0, x);
        bus_start();
        send_byte(abyte(1'b0, 1'b1), 1'b0, x);
        recv_byte(1'b0, d);
        temp = 16'h1234;
        recv_byte(1'b1, d2);
        bus_stop();
        check("R6 temp high byte", d, 8'hFF);
        check("R6 temp low from snapshot", d2, 8'h80);
        rd_reg(8'h65, d);
        check("R6 temp low direct", d, 8'h34);

        // R5: acknowledged continuation on a plain register repeats it
        bus_start();
        send_byte(abyte(1'b0, 1'b0), 1'b0, x);
        send_byte(8'h5D, 1'b0, x);
        bus_start();
        send_byte(abyte(1'b0, 1'b1), 1'b0, x);
        recv_byte(1'b0, d);
        recv_byte(1'b1, d2);
        bus_stop();
        check("R5 first byte", d, 8'h5A);
        check("R5 no increment", d2, 8'h5A);

        // R5 + R8: pointer persists across STOP; NACK releases SDA
        bus_start();
        send_byte(abyte(1'b0, 1'b0), 1'b0, x);
        send_byte(8'h60, 1'b0, x);
        bus_stop();
        bus_start();
        send_byte(abyte(1'b0, 1'b1), 1'b0, x);
        recv_byte(1'b1, d);
        check("R8 released after NACK", sda_oe, 1'b0);
        bus_stop();
        check("R5 pointer kept", d, 8'h0B);

        // R2: bytes without START are ignored
        scl_m = 1'b0; wq();
        send_byte(abyte(1'b0, 1'b0), 1'b0, ak);
        send_byte(8'h66, 1'b0, x);
        send_byte(8'h33, 1'b0, x);
        bus_stop();
        check("R2 no START not acked", ak, 1'b0);
        check("R2 no START no write", tune_o, 8'h22);

        finish_run();
    end
endmodule